// File: doc/BRIEF.md
# Pulse-Count Current-Limit Decoder

This block turns a short burst of pulses on one enable line into a 3-bit step. The step selects the peak current limit of a switching charger. The line is asynchronous to the system clock, so a synchronizer samples it first and an edge detector follows. The first rising edge opens a setup window of fixed length. Rising edges that arrive early enough in that window are counted. The count saturates after eight edges. When the window closes, the step is latched and a one-cycle strobe tells the switching controller that it may start.

The latched step, and a percentage code derived from it, stay valid only while the line stays high. A low level clears the setting, and the next burst programs a new one. The first high pulse has to be long. If it ends too early, the burst is dropped. Every limit is a parameter given in clock cycles.

Top module: `ilim_pulse_decoder`

## Requirements
- R1: While reset is applied, and at any time no setting is latched, `lim_valid_o`, `lim_step_o` and `lim_pct_o` are all 0 and `setup_done_o` is low.
- R2: A burst of n counted rising edges, with n from 1 to 8, latches step n-1. The percentage code for steps 0 to 7 is 100, 93, 86, 79, 71, 64, 57 and 50 in that order, so step 0 is the full limit.
- R3: Counted edges beyond the eighth leave the step at 7, which is 50 percent.
- R4: The setting becomes valid exactly when the setup window of `SETUP_CYC` cycles, counted from the first detected edge, has elapsed. At that moment `setup_done_o` pulses high for one cycle. This happens once per burst, and `lim_valid_o` stays low during the window.
- R5: If the first high pulse lasts fewer than `FIRST_MIN_CYC` cycles, the burst is abandoned. No setting is latched and no strobe is given, and the next rising edge starts a fresh burst.
- R6: A rising edge detected `EDGE_WIN_CYC` or more cycles after the first edge is not counted.
- R7: While the line stays high, a latched step and percentage do not change.
- R8: A low level on the line after a setting is latched clears the valid flag, the step and the percentage within a few cycles. A later burst then latches its own value.
- R9: Later pulses with high and low times of 2 clock cycles or more are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_in | input | 1 | Asynchronous enable and programming line |
| lim_step_o | output | 3 | Latched step index, 0 = full limit |
| lim_pct_o | output | 7 | Latched limit as a percentage of full scale |
| lim_valid_o | output | 1 | Setting latched, switching allowed |
| setup_done_o | output | 1 | One-cycle strobe when the setup window closes |

## Verification
The assertions check three properties on every cycle:
- a latched step never moves while the setting stays valid;
- the count stays at its ceiling once it reaches it;
- the strobe only coincides with entry into the latched state after a full window, and the percentage code stays inside its legal range.

The bench scenarios show the rest:
- the mapping from edge count to step;
- the abort on a short first pulse;
- the edges ignored after the deadline;
- reprogramming after the line drops.

Each of these needs a whole burst, timed from outside, to be observed at the ports.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

    localparam int PCT_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_WINDOW = 2'd2,
        ST_LOCKED = 2'd3
    } dec_state_e;

    // Percentage for step k of `steps` levels spread evenly from 100 down to 50, rounded.
    function automatic logic [PCT_W-1:0] pct_for(input int k, input int steps);
        int den;
        int val;
        if (steps <= 1) begin
            val = 100;
        end else begin
            den = 2 * (steps - 1);
            val = 100 - ((100 * k + (steps - 1)) / den);
        end
        return PCT_W'(val);
    endfunction

endpackage

// File: rtl/ilim_sync.sv
module ilim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("ilim_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], din};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.chain[STAGES-1];
    assign rise_o  = sync_q.chain[STAGES-1] & ~sync_q.prev;

endmodule

// File: rtl/ilim_ctrl.sv
module ilim_ctrl
    import ilim_pkg::*;
#(
    parameter int STEPS         = 8,
    parameter int FIRST_MIN_CYC = 1500,
    parameter int EDGE_WIN_CYC  = 4000,
    parameter int SETUP_CYC     = 4500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     level_i,
    input  logic                     rise_i,
    output logic [$clog2(STEPS)-1:0] step_o,
    output logic                     valid_o,
    output logic                     done_o
);

    localparam int STEP_W = $clog2(STEPS);
    localparam int TIM_W  = $clog2(SETUP_CYC + 1);
    localparam logic [STEP_W-1:0] STEP_MAX  = STEP_W'(STEPS - 1);
    localparam logic [TIM_W-1:0]  T_FIRST   = TIM_W'(FIRST_MIN_CYC - 1);
    localparam logic [TIM_W-1:0]  T_DEADL   = TIM_W'(EDGE_WIN_CYC);
    localparam logic [TIM_W-1:0]  T_CLOSE   = TIM_W'(SETUP_CYC - 1);

    typedef struct packed {
        dec_state_e        state;
        logic [TIM_W-1:0]  timer;
        logic [STEP_W-1:0] cnt;
        logic              done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.timer = '0;
                ctl_d.cnt   = '0;
                if (rise_i) begin
                    ctl_d.state = ST_FIRST;
                    ctl_d.timer = TIM_W'(1);
                end
            end
            ST_FIRST: begin
                ctl_d.timer = ctl_q.timer + 1'b1;
                if (!level_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.timer = '0;
                end else if (ctl_q.timer >= T_FIRST) begin
                    ctl_d.state = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (rise_i && (ctl_q.timer < T_DEADL) && (ctl_q.cnt != STEP_MAX)) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                if (ctl_q.timer == T_CLOSE) begin
                    ctl_d.state = ST_LOCKED;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.timer = ctl_q.timer + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (!level_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.timer = '0;
                    ctl_d.cnt   = '0;
                end
            end
            default: ctl_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign valid_o = (ctl_q.state == ST_LOCKED);
    assign step_o  = valid_o ? ctl_q.cnt : '0;
    assign done_o  = ctl_q.done;

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOCKED && $past(ctl_q.state) == ST_LOCKED) |-> $stable(ctl_q.cnt)); // R7

    AST_DONE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> (ctl_q.state == ST_LOCKED && $past(ctl_q.state) == ST_WINDOW)); // R4

    AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOCKED && $past(ctl_q.state) != ST_LOCKED) |-> $past(ctl_q.timer) == T_CLOSE); // R4

    AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WINDOW && $past(ctl_q.state) == ST_WINDOW && $past(ctl_q.cnt) == STEP_MAX)
        |-> ctl_q.cnt == STEP_MAX); // R3

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !level_i) |=> !valid_o); // R8

endmodule

// File: rtl/ilim_pct_map.sv
module ilim_pct_map
    import ilim_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic [$clog2(STEPS)-1:0] step_i,
    input  logic                     valid_i,
    output logic [PCT_W-1:0]         pct_o
);

    logic [PCT_W-1:0] lut [STEPS];

    generate
        for (genvar k = 0; k < STEPS; k++) begin : g_lut
            assign lut[k] = pct_for(k, STEPS);
        end
    endgenerate

    always_comb begin
        pct_o = '0;
        if (valid_i) begin
            pct_o = lut[step_i];
        end
    end

endmodule

// File: rtl/ilim_pulse_decoder.sv
module ilim_pulse_decoder
    import ilim_pkg::*;
#(
    parameter int STEPS         = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int FIRST_MIN_CYC = 1500,
    parameter int EDGE_WIN_CYC  = 4000,
    parameter int SETUP_CYC     = 4500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_in,
    output logic [$clog2(STEPS)-1:0] lim_step_o,
    output logic [PCT_W-1:0]         lim_pct_o,
    output logic                     lim_valid_o,
    output logic                     setup_done_o
);

    logic line_level;
    logic line_rise;

    ilim_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (prog_in),
        .level_o (line_level),
        .rise_o  (line_rise)
    );

    ilim_ctrl #(
        .STEPS         (STEPS),
        .FIRST_MIN_CYC (FIRST_MIN_CYC),
        .EDGE_WIN_CYC  (EDGE_WIN_CYC),
        .SETUP_CYC     (SETUP_CYC)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (line_level),
        .rise_i  (line_rise),
        .step_o  (lim_step_o),
        .valid_o (lim_valid_o),
        .done_o  (setup_done_o)
    );

    ilim_pct_map #(
        .STEPS (STEPS)
    ) i_pct (
        .step_i  (lim_step_o),
        .valid_i (lim_valid_o),
        .pct_o   (lim_pct_o)
    );

    AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lim_valid_o |-> (lim_pct_o >= PCT_W'(50) && lim_pct_o <= PCT_W'(100))); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_valid_o |-> (lim_pct_o == '0 && lim_step_o == '0 && !setup_done_o)); // R1

endmodule

// File: tb/test_ilim_pulse_decoder.sv
module test_ilim_pulse_decoder;

    localparam int FIRST_MIN = 1500;
    localparam int EDGE_WIN  = 4000;
    localparam int SETUP     = 4500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_in = 1'b0;
    logic [2:0] lim_step_o;
    logic [6:0] lim_pct_o;
    logic       lim_valid_o;
    logic       setup_done_o;

    int n_chk = 0;
    int n_bad = 0;
    int strobes = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ilim_pulse_decoder i_ilim_pulse_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_in      (prog_in),
        .lim_step_o   (lim_step_o),
        .lim_pct_o    (lim_pct_o),
        .lim_valid_o  (lim_valid_o),
        .setup_done_o (setup_done_o)
    );

    always @(negedge clk) begin
        cycles++;
        if (setup_done_o) strobes++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int exp_pct(input int step);
        case (step)
            0: return 100;
            1: return 93;
            2: return 86;
            3: return 79;
            4: return 71;
            5: return 64;
            6: return 57;
            default: return 50;
        endcase
    endfunction

    function automatic int exp_step(input int edges);
        return (edges >= 8) ? 7 : edges - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input bit v, input int n);
        prog_in = v;
        repeat (n) @(negedge clk);
    endtask

    // Drives a burst and leaves the line high; returns elapsed cycles since the first rise.
    task automatic burst(input int first_w, input int edges, input int hw, input int lw, output int el);
        el = 0;
        hold(1'b1, first_w);
        el += first_w;
        for (int i = 1; i < edges; i++) begin
            hold(1'b0, lw);
            hold(1'b1, hw);
            el += lw + hw;
        end
    endtask

    task automatic settle(input int el, input int target);
        if (target > el) repeat (target - el) @(negedge clk);
    endtask

    task automatic expect_locked(input string req, input int step);
        check({req, " valid"}, int'(lim_valid_o), 1);
        check({req, " step"}, int'(lim_step_o), step);
        check({req, " pct"}, int'(lim_pct_o), exp_pct(step));
        check({req, " strobes"}, strobes, 1);
    endtask

    task automatic release_line();
        hold(1'b0, 20);
        check("R8 cleared valid", int'(lim_valid_o), 0);
        check("R8 cleared pct", int'(lim_pct_o), 0);
        strobes = 0;
    endtask

    initial begin
        int el;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid in reset", int'(lim_valid_o), 0);
        check("R1 step in reset", int'(lim_step_o), 0);
        check("R1 pct in reset", int'(lim_pct_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 strobe idle", strobes, 0);

        // R4: not valid before window close, then valid with one strobe (R2, 3 edges)
        burst(1600, 3, 30, 30, el);
        settle(el, SETUP - 20);
        check("R4 not yet valid", int'(lim_valid_o), 0);
        check("R4 no early strobe", strobes, 0);
        settle(SETUP - 20, SETUP + 20);
        expect_locked("R4 R2 three edges", 2);
        // R7 stays put while high
        repeat (500) @(negedge clk);
        check("R7 step held", int'(lim_step_o), 2);
        check("R7 pct held", int'(lim_pct_o), 86);
        release_line();

        // R2 single edge = full limit
        burst(1600, 1, 0, 0, el);
        settle(el, SETUP + 20);
        expect_locked("R2 one edge", 0);
        release_line();

        // R3 saturation with 11 edges
        burst(1600, 11, 25, 25, el);
        settle(el, SETUP + 20);
        expect_locked("R3 saturate", 7);
        release_line();

        // R9 minimum-width later pulses (2 cycles high/low), 8 edges
        burst(1600, 8, 2, 2, el);
        settle(el, SETUP + 20);
        expect_locked("R9 narrow pulses", 7);
        release_line();

        // R5 short first pulse aborts
        hold(1'b1, 1000);
        hold(1'b0, SETUP);
        check("R5 no setting", int'(lim_valid_o), 0);
        check("R5 no strobe", strobes, 0);
        // R5 next burst starts fresh (4 edges)
        burst(1600, 4, 40, 40, el);
        settle(el, SETUP + 20);
        expect_locked("R5 fresh burst", 3);
        release_line();

        // R6 edges after the deadline ignored: 2 in time, then 2 late
        burst(1600, 2, 40, 40, el);
        hold(1'b0, EDGE_WIN + 100 - el);
        hold(1'b1, 40);
        hold(1'b0, 40);
        hold(1'b1, 40);
        el = EDGE_WIN + 100 + 120;
        settle(el, SETUP + 20);
        expect_locked("R6 late edges", 1);
        release_line();

        // R8 reprogram after drop: random bursts with various patterns
        for (int r = 0; r < 16; r++) begin
            int fw, ne, hw, lw;
            fw = 1550 + int'($urandom_range(0, 950));
            ne = 1 + int'($urandom_range(0, 9));
            hw = 2 + int'($urandom_range(0, 58));
            lw = 2 + int'($urandom_range(0, 58));
            burst(fw, ne, hw, lw, el);
            settle(el, SETUP + 20);
            expect_locked("R2 R8 random burst", exp_step(ne));
            release_line();
        end

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule